// File: doc/BRIEF.md
# Programmable Event Counter Bank

This block holds the optional event counters that sit next to a processor's fixed cycle and retired-instruction counters. Each slot, numbered 3 to 31, has three parts: a counter of parameterised width, which software sees as a low and a high 32-bit word, and an event-select mask. Each cycle the slot is compared against a vector of single-cycle event pulses. A shared inhibit word lets software freeze any slot on its own.

Software reaches the bank through a simple CSR port. The port carries an enable, a write strobe, a 12-bit address and write data, and returns read data in the same cycle. A privilege input says whether the access comes from machine mode. Machine-mode accesses never trap. Slots beyond the configured count read as zero and drop writes. Any access to a bank address from a lower privilege level raises an illegal-access flag and has no effect.

Top module: `hpm_bank`

## Requirements
- R1: After reset every counter word, every event-select mask and the inhibit word read as zero.
- R2: Slot k (3..31) exists when k-3 < NUM_CNT. Its low word is at 0xB00+k, its high word at 0xB80+k and its event select at 0x320+k. The inhibit word is at 0x320, and bit k of that word belongs to slot k.
- R3: In a cycle where the AND of a slot's event-select mask and `evt_i` is non-zero and its inhibit bit is clear, the slot's counter rises by exactly one. Otherwise it holds its value.
- R4: A counter is CNT_W bits wide. The carry from the low word into the high word takes effect in the same cycle. Bits at or above CNT_W read as zero and drop writes, and the counter wraps to zero after reaching its all-ones value.
- R5: A set inhibit bit stops its slot from counting. Inhibit bits 0 to 2, and the bits of slots that do not exist, read as zero.
- R6: In machine mode, the addresses of a slot that does not exist read as zero, drop writes and never raise `csr_illegal`.
- R7: An enabled access to any bank address with `priv_m` low raises `csr_illegal` in the same cycle, returns zero and changes no state.
- R8: The counter-enable word at 0x306 reads as zero and drops writes, without trapping in machine mode.
- R9: A write to either word of a counter takes priority over that counter's increment in the same cycle.
- R10: Read data is valid in the cycle of the access. When `csr_en` is low, or the address lies outside the bank, `csr_rdata` is zero and `csr_illegal` is low.
- R11: An event-select mask keeps EVT_W bits, and its upper bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_en | input | 1 | CSR access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write data |
| priv_m | input | 1 | High when the access comes from machine mode |
| evt_i | input | EVT_W | Event pulses, one bit per event source |
| csr_rdata | output | 32 | Read data, combinational |
| csr_illegal | output | 1 | Disallowed access flag |

## Verification
Some rules are checked on every cycle. Machine mode never traps, and a trapped or idle access returns zero. A user-mode write leaves the inhibit word untouched. The first counter either holds or steps by exactly one unless software wrote it, and it freezes while its inhibit bit is set. Other behaviour can only be shown by the bench's scenarios against its own model: the address map, counter width and wrap, the same-cycle carry between words, write-over-increment priority, and the silence of unimplemented slots and the enable word.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_LO,
        K_HI,
        K_SEL,
        K_INH,
        K_EN
    } kind_t;

    localparam logic [11:0] A_LO_BASE  = 12'hB00;
    localparam logic [11:0] A_HI_BASE  = 12'hB80;
    localparam logic [11:0] A_SEL_BASE = 12'h320;
    localparam logic [11:0] A_ENABLE   = 12'h306;
    localparam int          FIRST_SLOT = 3;
    localparam int          MAX_SLOTS  = 29;

    // bits FIRST_SLOT .. FIRST_SLOT+n-1 set
    function automatic logic [31:0] impl_mask(input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < MAX_SLOTS; i++) begin
            if (i < n) m[i + FIRST_SLOT] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [63:0] width_mask(input int w);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i < w) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/hpm_decode.sv
module hpm_decode
    import hpm_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input  logic [11:0] addr_i,
    output kind_t       kind_o,
    output logic [4:0]  slot_o,
    output logic        impl_o
);

    localparam logic [5:0] NUM_W = 6'(NUM_CNT);

    logic [4:0] idx;
    logic       idx_ok;

    assign idx    = addr_i[4:0];
    assign idx_ok = (idx >= 5'(FIRST_SLOT));

    always_comb begin
        kind_o = K_NONE;
        if (addr_i == A_ENABLE) begin
            kind_o = K_EN;
        end else if (addr_i[11:5] == A_LO_BASE[11:5]) begin
            if (idx_ok) kind_o = K_LO;
        end else if (addr_i[11:5] == A_HI_BASE[11:5]) begin
            if (idx_ok) kind_o = K_HI;
        end else if (addr_i[11:5] == A_SEL_BASE[11:5]) begin
            if (idx == 5'd0)  kind_o = K_INH;
            else if (idx_ok)  kind_o = K_SEL;
        end
    end

    assign slot_o = idx - 5'(FIRST_SLOT);
    assign impl_o = idx_ok && ({1'b0, slot_o} < NUM_W);

endmodule

// File: rtl/hpm_counter.sv
module hpm_counter
    import hpm_pkg::*;
#(
    parameter int CNT_W = 40,
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             inhibit_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic             wr_sel_i,
    input  logic [31:0]      wdata_i,
    output logic [63:0]      value_o,
    output logic [EVT_W-1:0] sel_o
);

    localparam logic [63:0] CMASK = width_mask(CNT_W);

    typedef struct packed {
        logic [63:0]      cnt;
        logic [EVT_W-1:0] sel;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    hit;

    assign hit = (|(st_q.sel & evt_i)) && !inhibit_i;

    always_comb begin
        st_d = st_q;
        if (wr_lo_i) begin
            st_d.cnt = {st_q.cnt[63:32], wdata_i} & CMASK;
        end else if (wr_hi_i) begin
            st_d.cnt = {wdata_i, st_q.cnt[31:0]} & CMASK;
        end else if (hit) begin
            st_d.cnt = (st_q.cnt + 64'd1) & CMASK;
        end
        if (wr_sel_i) begin
            st_d.sel = wdata_i[EVT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value_o = st_q.cnt;
    assign sel_o   = st_q.sel;

endmodule

// File: rtl/hpm_bank.sv
module hpm_bank
    import hpm_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 40,
    parameter int EVT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_en,
    input  logic             csr_we,
    input  logic [11:0]      csr_addr,
    input  logic [31:0]      csr_wdata,
    input  logic             priv_m,
    input  logic [EVT_W-1:0] evt_i,
    output logic [31:0]      csr_rdata,
    output logic             csr_illegal
);

    localparam int          NSLOT = (NUM_CNT == 0) ? 1 : NUM_CNT;
    localparam logic [31:0] IMASK = impl_mask(NUM_CNT);

    typedef struct packed {
        logic [31:0] inh;
    } bank_st_t;

    bank_st_t    st_d, st_q;
    kind_t       kind;
    logic [4:0]  slot;
    logic        impl;
    logic        in_bank;
    logic        wr_ok;
    logic [63:0]      cnt_val [NSLOT];
    logic [EVT_W-1:0] sel_val [NSLOT];
    logic [63:0]      rd_cnt;
    logic [EVT_W-1:0] rd_sel;

    hpm_decode #(.NUM_CNT(NUM_CNT)) u_dec (
        .addr_i (csr_addr),
        .kind_o (kind),
        .slot_o (slot),
        .impl_o (impl)
    );

    assign in_bank     = (kind != K_NONE);
    assign wr_ok       = csr_en && csr_we && priv_m;
    assign csr_illegal = csr_en && in_bank && !priv_m;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if (g < NUM_CNT) begin : g_impl
            hpm_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_cnt (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt_i     (evt_i),
                .inhibit_i (st_q.inh[g + FIRST_SLOT]),
                .wr_lo_i   (wr_ok && kind == K_LO  && slot == 5'(g)),
                .wr_hi_i   (wr_ok && kind == K_HI  && slot == 5'(g)),
                .wr_sel_i  (wr_ok && kind == K_SEL && slot == 5'(g)),
                .wdata_i   (csr_wdata),
                .value_o   (cnt_val[g]),
                .sel_o     (sel_val[g])
            );
        end else begin : g_none
            assign cnt_val[g] = '0;
            assign sel_val[g] = '0;
        end
    end

    always_comb begin
        rd_cnt = '0;
        rd_sel = '0;
        for (int k = 0; k < NSLOT; k++) begin
            if (slot == 5'(k)) begin
                rd_cnt = cnt_val[k];
                rd_sel = sel_val[k];
            end
        end
    end

    always_comb begin
        csr_rdata = '0;
        if (csr_en && priv_m) begin
            unique case (kind)
                K_LO:    if (impl) csr_rdata = rd_cnt[31:0];
                K_HI:    if (impl) csr_rdata = rd_cnt[63:32];
                K_SEL:   if (impl) csr_rdata = 32'(rd_sel);
                K_INH:   csr_rdata = st_q.inh;
                default: csr_rdata = '0;
            endcase
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_ok && kind == K_INH) begin
            st_d.inh = csr_wdata & IMASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/hpm_bank_chk.sv
module hpm_bank_chk
    import hpm_pkg::*;
#(
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 40
) (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_en,
    input logic        csr_we,
    input logic [11:0] csr_addr,
    input logic        priv_m,
    input logic [31:0] csr_rdata,
    input logic        csr_illegal,
    input logic [31:0] inh_q,
    input logic [63:0] cnt0
);

    localparam logic [63:0] CMASK = width_mask(CNT_W);

    logic w0;
    assign w0 = csr_en && csr_we && priv_m &&
                (csr_addr == 12'hB03 || csr_addr == 12'hB83);

    p_machine_notrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        priv_m |-> !csr_illegal);

    p_trap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_rdata == 32'd0);

    p_user_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && csr_we && !priv_m) |=> $stable(inh_q));

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_en |-> (csr_rdata == 32'd0 && !csr_illegal));

    if (NUM_CNT > 0) begin : g_c0
        p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !w0 |=> (cnt0 == $past(cnt0) ||
                     cnt0 == (($past(cnt0) + 64'd1) & CMASK)));

        p_inhibit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (inh_q[FIRST_SLOT] && !w0) |=> $stable(cnt0));
    end

endmodule

bind hpm_bank hpm_bank_chk #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_en      (csr_en),
    .csr_we      (csr_we),
    .csr_addr    (csr_addr),
    .priv_m      (priv_m),
    .csr_rdata   (csr_rdata),
    .csr_illegal (csr_illegal),
    .inh_q       (st_q.inh),
    .cnt0        (cnt_val[0])
);

// File: tb/test_hpm_bank.sv
`timescale 1ns/1ps
module test_hpm_bank;

    localparam int NUM_CNT = 4;
    localparam int CNT_W   = 40;
    localparam int EVT_W   = 8;
    localparam logic [63:0] CMASK = (64'd1 << CNT_W) - 64'd1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             csr_en = 1'b0, csr_we = 1'b0, priv_m = 1'b1;
    logic [11:0]      csr_addr = '0;
    logic [31:0]      csr_wdata = '0;
    logic [EVT_W-1:0] evt_i = '0;
    logic [31:0]      csr_rdata;
    logic             csr_illegal;

    int errors = 0;
    int checks = 0;

    logic [63:0] m_cnt [29];
    logic [31:0] m_sel [29];
    logic [31:0] m_inh;

    always #2 clk = ~clk;

    hpm_bank #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .EVT_W(EVT_W)) i_hpm_bank (
        .clk(clk), .rst_n(rst_n), .csr_en(csr_en), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .priv_m(priv_m),
        .evt_i(evt_i), .csr_rdata(csr_rdata), .csr_illegal(csr_illegal)
    );

    function automatic bit in_bank(input logic [11:0] a);
        if (a == 12'h306) return 1;
        if (a == 12'h320) return 1;
        if (a[4:0] < 5'd3) return 0;
        return (a[11:5] == 7'h58) || (a[11:5] == 7'h5C) || (a[11:5] == 7'h19);
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int k;
        k = int'(a[4:0]) - 3;
        if (!csr_en || !priv_m) return 32'd0;
        if (a == 12'h320) return m_inh;
        if (!in_bank(a) || a == 12'h306 || k >= NUM_CNT) return 32'd0;
        if (a[11:5] == 7'h58) return m_cnt[k][31:0];
        if (a[11:5] == 7'h5C) return m_cnt[k][63:32];
        return m_sel[k];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic [63:0] n_cnt [29];
        logic [31:0] n_sel [29];
        logic [31:0] n_inh;
        bit wr;
        wr = csr_en && csr_we && priv_m;
        n_inh = m_inh;
        for (int k = 0; k < 29; k++) begin
            n_cnt[k] = m_cnt[k];
            n_sel[k] = m_sel[k];
        end
        if (wr && csr_addr == 12'h320) n_inh = csr_wdata & (((32'd1 << NUM_CNT) - 1) << 3);
        for (int k = 0; k < NUM_CNT; k++) begin
            if (wr && csr_addr == 12'hB03 + 12'(k))
                n_cnt[k] = {m_cnt[k][63:32], csr_wdata} & CMASK;
            else if (wr && csr_addr == 12'hB83 + 12'(k))
                n_cnt[k] = {csr_wdata, m_cnt[k][31:0]} & CMASK;
            else if (((m_sel[k] & 32'(evt_i)) != 0) && !m_inh[k + 3])
                n_cnt[k] = (m_cnt[k] + 64'd1) & CMASK;
            if (wr && csr_addr == 12'h323 + 12'(k))
                n_sel[k] = csr_wdata & ((32'd1 << EVT_W) - 1);
        end
        @(posedge clk);
        m_inh = n_inh;
        for (int k = 0; k < 29; k++) begin
            m_cnt[k] = n_cnt[k];
            m_sel[k] = n_sel[k];
        end
        @(negedge clk);
    endtask

    // one access cycle: drive, check comb outputs, advance model
    task automatic tick(input string tag, input bit en, input bit we,
                        input logic [11:0] a, input logic [31:0] d,
                        input bit pm, input logic [EVT_W-1:0] ev);
        csr_en = en; csr_we = we; csr_addr = a; csr_wdata = d;
        priv_m = pm; evt_i = ev;
        #1;
        check(tag, csr_rdata, exp_read(a));
        check(tag, 32'(csr_illegal), 32'(en && !pm && in_bank(a)));
        model_step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_inh = '0;
        for (int k = 0; k < 29; k++) begin m_cnt[k] = '0; m_sel[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        tick("R1 low word", 1, 0, 12'hB03, 0, 1, '0);
        tick("R1 high word", 1, 0, 12'hB86, 0, 1, '0);
        tick("R1 select", 1, 0, 12'h324, 0, 1, '0);
        tick("R1 inhibit", 1, 0, 12'h320, 0, 1, '0);

        // R8 enable word
        tick("R8 write", 1, 1, 12'h306, 32'hFFFF_FFFF, 1, '0);
        tick("R8 read", 1, 0, 12'h306, 0, 1, '0);

        // R3 counting by event match
        tick("R2 sel write", 1, 1, 12'h323, 32'h01, 1, '0);
        for (int i = 0; i < 5; i++) tick("R3 count", 0, 0, 0, 0, 1, 8'h01);
        tick("R3 five events", 1, 0, 12'hB03, 0, 1, 8'h02);
        tick("R3 no match hold", 1, 0, 12'hB03, 0, 1, '0);

        // R5 inhibit
        tick("R5 inhibit write", 1, 1, 12'h320, 32'hFFFF_FFFF, 1, 8'h01);
        tick("R5 inhibit read", 1, 0, 12'h320, 0, 1, 8'h01);
        tick("R5 frozen", 1, 0, 12'hB03, 0, 1, 8'h01);
        tick("R5 release", 1, 1, 12'h320, 32'h0, 1, 8'h00);

        // R4 carry and wrap
        tick("R4 lo", 1, 1, 12'hB03, 32'hFFFF_FFFF, 1, '0);
        tick("R4 hi", 1, 1, 12'hB83, 32'h0, 1, '0);
        tick("R4 carry step", 0, 0, 0, 0, 1, 8'h01);
        tick("R4 carry lo", 1, 0, 12'hB03, 0, 1, '0);
        tick("R4 carry hi", 1, 0, 12'hB83, 0, 1, '0);
        tick("R4 hi full", 1, 1, 12'hB83, 32'hFFFF_FFFF, 1, '0);
        tick("R4 hi masked", 1, 0, 12'hB83, 0, 1, '0);
        tick("R4 lo full", 1, 1, 12'hB03, 32'hFFFF_FFFF, 1, '0);
        tick("R4 wrap step", 0, 0, 0, 0, 1, 8'h01);
        tick("R4 wrap hi", 1, 0, 12'hB83, 0, 1, '0);

        // R9 write beats increment
        tick("R9 write with event", 1, 1, 12'hB03, 32'h1234, 1, 8'h01);
        tick("R9 written value", 1, 0, 12'hB03, 0, 1, '0);

        // R6 unimplemented slot 10
        tick("R6 write", 1, 1, 12'hB0A, 32'hDEAD, 1, '0);
        tick("R6 read", 1, 0, 12'hB0A, 0, 1, '0);
        tick("R6 sel read", 1, 0, 12'h32A, 0, 1, '0);

        // R7 user mode
        tick("R7 user write", 1, 1, 12'h320, 32'hFF, 0, '0);
        tick("R7 user read", 1, 0, 12'hB03, 0, 0, '0);
        tick("R7 inhibit kept", 1, 0, 12'h320, 0, 1, '0);

        // R11 select width
        tick("R11 sel write", 1, 1, 12'h325, 32'hFFFF_FFFF, 1, '0);
        tick("R11 sel read", 1, 0, 12'h325, 0, 1, '0);

        // R10 outside bank and idle
        tick("R10 outside", 1, 1, 12'h300, 32'h5, 0, '0);
        tick("R10 fixed counter", 1, 0, 12'hB00, 0, 1, '0);
        tick("R10 idle", 0, 0, 12'hB03, 0, 0, '0);

        // random mix, R2 address map under traffic
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            int k;
            int sel;
            k = 3 + int'($urandom % 29);
            if ($urandom % 2 == 0) k = 3 + int'($urandom % (NUM_CNT + 1));
            sel = int'($urandom % 7);
            case (sel)
                0: a = 12'hB00 + 12'(k);
                1: a = 12'hB80 + 12'(k);
                2: a = 12'h320 + 12'(k);
                3: a = 12'h320;
                4: a = 12'h306;
                5: a = 12'h300 + 12'($urandom % 4);
                default: a = 12'hB00 + 12'(k);
            endcase
            tick("R2 random", ($urandom % 4) != 0, ($urandom % 4) == 0, a,
                 $urandom, ($urandom % 5) != 0, 8'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule